// File: doc/BRIEF.md
# SDRAM Command Monitor

This block sits beside the command pins of a four-bank synchronous DRAM interface and samples them on every rising clock edge. Each sampled edge is turned into a command code together with the bank it targets. A model of every bank (idle, open, running an auto-precharge burst, or recovering from one) is kept, and a one-cycle error pulse with a reason code is raised for any command that breaks the device's ordering rules. Commands are registered, so the code, bank, error and updated bank states appear one cycle after the edge that sampled them.

A command that is flagged leaves every bank model untouched, so the monitor keeps describing what a legal device would hold. The block also derives the two data-mask timings: a write mask that follows the mask pin in the same cycle, and a read high-impedance strobe delayed by two edges.

Burst length, precharge recovery time and the guard after a mode set are parameters; the bank count follows from the two bank-select bits.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` high the command code is 9 (deselect). With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as 000 mode set (1), 001 refresh (2, or 3 for self-refresh entry when `cke` is low), 011 activate (4), 101 read (5), 100 write (6), 010 precharge (7), 110 burst stop (8), 111 no-operation (0). `cmd_o` shows the code one cycle after the sampling edge, and is 0 after reset.
- R2: The target bank index reported on `bank_o` is {`ba[0]`,`ba[1]`}: `ba`=00 gives bank 0, `ba[1]` high alone gives bank 1, `ba[0]` high alone gives bank 2, both high give bank 3. Bank b's state is `bank_state_o[2b+1:2b]`.
- R3: `wr_mask_o` equals `dqm` in the same cycle; `rd_hiz_o` equals the `dqm` value sampled two rising edges earlier.
- R4: A mode set while any bank is not idle (state 0) gives error code 1.
- R5: For the two edges after an accepted mode set, any command other than no-operation or deselect gives error code 3; this check takes priority over all others.
- R6: Refresh or self-refresh entry while any bank is not idle gives error code 2.
- R7: Activate to an idle bank moves it to state 1 (open); activate to a bank in state 1 or 2 gives error code 4.
- R8: Read or write to a bank that is not in state 1 gives error code 6 (when R10 does not apply).
- R9: Read or write with `ap` high moves the bank to state 2 for the next BURST_LEN edges, then state 3 for TRP edges, then state 0; with `ap` low the bank stays in state 1.
- R10: Any read or write sampled while some bank is in state 2 gives error code 7.
- R11: Activate to a bank in state 3 gives error code 5; it is accepted from the first edge the bank is idle.
- R12: Precharge with `ap` high returns every open bank to idle whatever `ba` holds; with `ap` low only the selected bank.
- R13: Burst stop never raises an error.
- R14: `err_o` is high for exactly the cycle after a flagged command, `err_code_o` is 0 whenever `err_o` is low, and a flagged command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock, rising edge samples everything |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin, low marks refresh as self-refresh entry |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select bits |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| dqm | input | 1 | Data mask pin |
| cmd_o | output | 4 | Decoded command code (R1) |
| bank_o | output | 2 | Decoded bank index (R2) |
| bank_state_o | output | 8 | Two-bit state per bank |
| err_o | output | 1 | Rule violation pulse |
| err_code_o | output | 3 | Rule that was broken |
| wr_mask_o | output | 1 | Write data mask, latency 0 |
| rd_hiz_o | output | 1 | Read output high-impedance strobe, latency 2 |

## Verification
The assertions take for granted that the pins carry a defined value at every sampled edge and that the mask latency stays at two, since they compare the read strobe with the mask two edges back; they also rely on reset being held for at least one edge before any command. The stimulus drives every pin on the falling edge only, holds reset for several edges, and returns the pins to no-operation between commands. Each scenario ends by waiting out the longest burst, recovery and guard windows and issuing an all-banks precharge, so every case starts from all banks idle.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    localparam int BA_W = 2;
    localparam int NB   = 1 << BA_W;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_MODESET = 4'd1,
        CMD_REFRESH = 4'd2,
        CMD_SELFREF = 4'd3,
        CMD_ACT     = 4'd4,
        CMD_READ    = 4'd5,
        CMD_WRITE   = 4'd6,
        CMD_PRECH   = 4'd7,
        CMD_STOP    = 4'd8,
        CMD_DESEL   = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_APBURST = 2'd2,
        BK_RECOVER = 2'd3
    } bank_st_e;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_MODE_BUSY   = 3'd1,
        ERR_REF_BUSY    = 3'd2,
        ERR_MODE_GUARD  = 3'd3,
        ERR_ACT_OPEN    = 3'd4,
        ERR_ACT_RECOVER = 3'd5,
        ERR_RW_CLOSED   = 3'd6,
        ERR_RW_LOCKED   = 3'd7
    } err_e;

    typedef struct packed {
        cmd_e            cmd;
        logic [BA_W-1:0] bank;
        logic            ap;
    } cmd_t;

    // Pin combination to command code
    function automatic cmd_e decode_pins(logic cs_n, logic ras_n, logic cas_n,
                                         logic we_n, logic cke);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  c = CMD_MODESET;
                3'b001:  c = cke ? CMD_REFRESH : CMD_SELFREF;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b010:  c = CMD_PRECH;
                3'b110:  c = CMD_STOP;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    // Bank index is the select bits in reversed order
    function automatic logic [BA_W-1:0] bank_of(logic [BA_W-1:0] ba);
        logic [BA_W-1:0] r;
        for (int i = 0; i < BA_W; i++) begin
            r[i] = ba[BA_W-1-i];
        end
        return r;
    endfunction

    function automatic logic is_quiet(cmd_e c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            cke,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    output cmd_t            cmd_o
);

    always_comb begin
        cmd_o.cmd  = decode_pins(cs_n, ras_n, cas_n, we_n, cke);
        cmd_o.bank = bank_of(ba);
        cmd_o.ap   = ap;
    end

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
    import sdram_mon_pkg::*;
#(
    parameter int BANKS = NB
) (
    input  cmd_t     cmd_i,
    input  bank_st_e st_i [BANKS],
    input  logic     guard_i,
    output err_e     err_o
);

    logic     all_idle;
    logic     any_burst;
    bank_st_e sel;

    always_comb begin
        all_idle  = 1'b1;
        any_burst = 1'b0;
        for (int i = 0; i < BANKS; i++) begin
            if (st_i[i] != BK_IDLE)    all_idle  = 1'b0;
            if (st_i[i] == BK_APBURST) any_burst = 1'b1;
        end
        sel = st_i[cmd_i.bank];
    end

    always_comb begin
        err_o = ERR_NONE;
        if (guard_i && !is_quiet(cmd_i.cmd)) begin
            err_o = ERR_MODE_GUARD;
        end else begin
            case (cmd_i.cmd)
                CMD_MODESET: if (!all_idle) err_o = ERR_MODE_BUSY;
                CMD_REFRESH,
                CMD_SELFREF: if (!all_idle) err_o = ERR_REF_BUSY;
                CMD_ACT: begin
                    if (sel == BK_RECOVER)   err_o = ERR_ACT_RECOVER;
                    else if (sel != BK_IDLE) err_o = ERR_ACT_OPEN;
                end
                CMD_READ,
                CMD_WRITE: begin
                    if (any_burst)           err_o = ERR_RW_LOCKED;
                    else if (sel != BK_OPEN) err_o = ERR_RW_CLOSED;
                end
                default: err_o = ERR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int TRP       = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     open_i,
    input  logic     access_i,
    input  logic     ap_i,
    input  logic     close_i,
    output bank_st_e state_o
);

    localparam int MAXC = (BURST_LEN > TRP) ? BURST_LEN : TRP;
    localparam int CW   = $clog2(MAXC + 1);

    bank_st_e      st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                BK_IDLE: begin
                    if (open_i) st <= BK_OPEN;
                end
                BK_OPEN: begin
                    if (access_i && ap_i) begin
                        st  <= BK_APBURST;
                        cnt <= CW'(BURST_LEN);
                    end else if (close_i) begin
                        st <= BK_IDLE;
                    end
                end
                BK_APBURST: begin
                    if (cnt == CW'(1)) begin
                        st  <= BK_RECOVER;
                        cnt <= CW'(TRP);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    if (cnt == CW'(1)) begin
                        st  <= BK_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    assign state_o = st;

endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dqm_i,
    output logic wr_mask_o,
    output logic rd_hiz_o
);

    assign wr_mask_o = dqm_i;

    generate
        if (RD_LAT == 0) begin : g_direct
            assign rd_hiz_o = dqm_i;
        end else if (RD_LAT == 1) begin : g_one
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= dqm_i;
            end
            assign rd_hiz_o = q;
        end else begin : g_shift
            logic [RD_LAT-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[RD_LAT-2:0], dqm_i};
            end
            assign rd_hiz_o = sh[RD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN   = 4,
    parameter int TRP         = 3,
    parameter int GUARD_CYC   = 2,
    parameter int RD_MASK_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [1:0]      ba,
    input  logic            ap,
    input  logic            dqm,
    output logic [3:0]      cmd_o,
    output logic [1:0]      bank_o,
    output logic [2*NB-1:0] bank_state_o,
    output logic            err_o,
    output logic [2:0]      err_code_o,
    output logic            wr_mask_o,
    output logic            rd_hiz_o
);

    localparam int GW = $clog2(GUARD_CYC + 1);

    cmd_t          cur;
    err_e          verdict;
    bank_st_e      st [NB];
    logic [GW-1:0] guard_cnt;
    logic          accept;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .ba    (ba),
        .ap    (ap),
        .cmd_o (cur)
    );

    sdram_rule_check #(.BANKS(NB)) u_rules (
        .cmd_i   (cur),
        .st_i    (st),
        .guard_i (guard_cnt != '0),
        .err_o   (verdict)
    );

    assign accept = (verdict == ERR_NONE);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            logic hit;
            assign hit = (cur.bank == BA_W'(b));
            sdram_bank_fsm #(
                .BURST_LEN (BURST_LEN),
                .TRP       (TRP)
            ) u_fsm (
                .clk      (clk),
                .rst      (rst),
                .open_i   (accept && cur.cmd == CMD_ACT && hit),
                .access_i (accept && (cur.cmd == CMD_READ || cur.cmd == CMD_WRITE) && hit),
                .ap_i     (cur.ap),
                .close_i  (accept && cur.cmd == CMD_PRECH && (cur.ap || hit)),
                .state_o  (st[b])
            );
            assign bank_state_o[2*b +: 2] = st[b];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            guard_cnt <= '0;
        end else if (accept && cur.cmd == CMD_MODESET) begin
            guard_cnt <= GW'(GUARD_CYC);
        end else if (guard_cnt != '0) begin
            guard_cnt <= guard_cnt - GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o      <= CMD_NOP;
            bank_o     <= '0;
            err_o      <= 1'b0;
            err_code_o <= ERR_NONE;
        end else begin
            cmd_o      <= cur.cmd;
            bank_o     <= cur.bank;
            err_o      <= !accept;
            err_code_o <= verdict;
        end
    end

    sdram_dqm_pipe #(.RD_LAT(RD_MASK_LAT)) u_dqm (
        .clk       (clk),
        .rst       (rst),
        .dqm_i     (dqm),
        .wr_mask_o (wr_mask_o),
        .rd_hiz_o  (rd_hiz_o)
    );

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
    parameter int BANKS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               dqm,
    input logic [3:0]         cmd_o,
    input logic               err_o,
    input logic [2:0]         err_code_o,
    input logic [2*BANKS-1:0] bank_state_o,
    input logic               rd_hiz_o
);

    logic [1:0] age;
    logic       all_idle;
    int         bursts;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    always_comb begin
        all_idle = 1'b1;
        bursts   = 0;
        for (int i = 0; i < BANKS; i++) begin
            if (bank_state_o[2*i +: 2] != 2'd0) all_idle = 1'b0;
            if (bank_state_o[2*i +: 2] == 2'd2) bursts   = bursts + 1;
        end
    end

    // R14: the reason code is present exactly when the pulse is
    a_r14_code_with_pulse: assert property (@(posedge clk) disable iff (rst)
        err_o == (err_code_o != 3'd0));

    // R5: nothing but quiet commands pass right after an accepted mode set
    a_r5_guard_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'd1 && !err_o) |=> (err_o || cmd_o == 4'd0 || cmd_o == 4'd9));

    // R3: read strobe follows the mask two edges later
    a_r3_read_lat: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (rd_hiz_o == $past(dqm, 2)));

    // R6: an accepted refresh found every bank idle
    a_r6_refresh_idle: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == 4'd2 || cmd_o == 4'd3) && !err_o) |-> $past(all_idle));

    // R10: auto-precharge bursts never overlap
    a_r10_one_burst: assert property (@(posedge clk) disable iff (rst)
        bursts <= 1);

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bk
            // R9: a burst only ends into recovery
            a_r9_burst_exit: assert property (@(posedge clk) disable iff (rst)
                (bank_state_o[2*b +: 2] == 2'd2) |=> bank_state_o[2*b + 1]);
        end
    endgenerate

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BANKS(sdram_mon_pkg::NB)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dqm          (dqm),
    .cmd_o        (cmd_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o),
    .bank_state_o (bank_state_o),
    .rd_hiz_o     (rd_hiz_o)
);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;

    localparam int BL = 4;
    localparam int TR = 3;
    localparam int C_NOP = 0, C_MS = 1, C_REF = 2, C_SREF = 3, C_ACT = 4,
                   C_RD = 5, C_WR = 6, C_PRE = 7, C_BST = 8, C_DES = 9;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0, dqm = 1'b0;
    logic [1:0] ba = 2'b00;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic [7:0] bank_state_o;
    logic err_o, wr_mask_o, rd_hiz_o;
    logic [2:0] err_code_o;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(.BURST_LEN(BL), .TRP(TR)) uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .dqm(dqm),
        .cmd_o(cmd_o), .bank_o(bank_o), .bank_state_o(bank_state_o),
        .err_o(err_o), .err_code_o(err_code_o), .wr_mask_o(wr_mask_o),
        .rd_hiz_o(rd_hiz_o)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int st(int b);
        return int'(bank_state_o[2*b +: 2]);
    endfunction

    function automatic int exp_code(int cs, int rcw, int k);
        if (cs != 0) return C_DES;
        case (rcw)
            0: return C_MS;
            1: return (k != 0) ? C_REF : C_SREF;
            2: return C_PRE;
            3: return C_ACT;
            4: return C_WR;
            5: return C_RD;
            6: return C_BST;
            default: return C_NOP;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; cke = 1'b1; ap = 1'b0;
    endtask

    task automatic raw(int cs, int rcw, int k, logic [1:0] bav, logic apv);
        cs_n = cs[0]; {ras_n, cas_n, we_n} = rcw[2:0]; cke = k[0];
        ba = bav; ap = apv;
        step();
    endtask

    task automatic issue(int c, int b, logic apv);
        int rcw;
        int k = 1;
        int cs = 0;
        case (c)
            C_MS:    rcw = 0;
            C_REF:   rcw = 1;
            C_SREF:  begin rcw = 1; k = 0; end
            C_ACT:   rcw = 3;
            C_RD:    rcw = 5;
            C_WR:    rcw = 4;
            C_PRE:   rcw = 2;
            C_BST:   rcw = 6;
            C_DES:   begin rcw = 7; cs = 1; end
            default: rcw = 7;
        endcase
        raw(cs, rcw, k, {b[0], b[1]}, apv);
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic expect_err(string tag, int code);
        check({tag, " pulse"}, int'(err_o), (code != 0) ? 1 : 0);
        check({tag, " code"}, int'(err_code_o), code);
    endtask

    task automatic clean();
        idle(BL + TR + 3);
        issue(C_PRE, 0, 1'b1);
        idle(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cs_n = 1'b0;
        check("R1 reset cmd", int'(cmd_o), C_NOP);
        check("R14 reset err", int'(err_o), 0);
        check("R9 reset states", int'(bank_state_o), 0);

        // R1: every pin combination
        for (int cs = 0; cs < 2; cs++)
            for (int rcw = 0; rcw < 8; rcw++)
                for (int k = 0; k < 2; k++) begin
                    raw(cs, rcw, k, 2'b00, 1'b0);
                    check("R1 decode", int'(cmd_o), exp_code(cs, rcw, k));
                end
        clean();

        // R2 and R12: bank mapping, then all-banks precharge
        for (int v = 0; v < 4; v++) begin
            raw(0, 3, 1, 2'(v), 1'b0);
            check("R2 bank", int'(bank_o), ((v & 1) << 1) | (v >> 1));
            check("R2 state", st(((v & 1) << 1) | (v >> 1)), 1);
        end
        issue(C_PRE, 3, 1'b1);
        check("R12 all idle", int'(bank_state_o), 0);
        issue(C_ACT, 0, 1'b0);
        issue(C_ACT, 2, 1'b0);
        issue(C_PRE, 2, 1'b0);
        check("R12 single closes", st(2), 0);
        check("R12 single keeps", st(0), 1);
        issue(C_RD, 0, 1'b0);
        expect_err("R8 open read", 0);
        check("R9 no ap stays open", st(0), 1);

        // R4, R14
        issue(C_MS, 0, 1'b0);
        expect_err("R4 busy", 1);
        check("R14 state kept", st(0), 1);
        idle(1);
        check("R14 one cycle", int'(err_o), 0);
        clean();

        // R5 guard sweep
        for (int g = 1; g <= 3; g++) begin
            issue(C_MS, 0, 1'b0);
            expect_err("R4 idle ok", 0);
            idle(g - 1);
            issue(C_ACT, 1, 1'b0);
            expect_err("R5 guard", (g <= 2) ? 3 : 0);
            check("R5 state", st(1), (g <= 2) ? 0 : 1);
            clean();
        end

        // R6
        issue(C_ACT, 3, 1'b0);
        issue(C_REF, 0, 1'b0);
        expect_err("R6 refresh busy", 2);
        issue(C_SREF, 0, 1'b0);
        expect_err("R6 selfref busy", 2);
        issue(C_PRE, 3, 1'b0);
        issue(C_REF, 0, 1'b0);
        expect_err("R6 refresh idle", 0);

        // R7, R8
        issue(C_ACT, 0, 1'b0);
        issue(C_ACT, 0, 1'b0);
        expect_err("R7 reopen", 4);
        issue(C_RD, 1, 1'b0);
        expect_err("R8 read closed", 6);
        issue(C_WR, 1, 1'b0);
        expect_err("R8 write closed", 6);
        check("R14 closed untouched", st(1), 0);
        clean();

        // R9, R11: activate after an auto-precharge write
        for (int g = 1; g <= BL + TR + 1; g++) begin
            issue(C_ACT, 0, 1'b0);
            issue(C_WR, 0, 1'b1);
            check("R9 burst state", st(0), 2);
            idle(g - 1);
            issue(C_ACT, 0, 1'b0);
            expect_err("R11 reopen gap", (g <= BL) ? 4 : ((g <= BL + TR) ? 5 : 0));
            if (g > BL + TR) check("R11 reopened", st(0), 1);
            clean();
        end

        // R10, R13: lock on other banks
        for (int g = 1; g <= BL + 1; g++) begin
            issue(C_ACT, 1, 1'b0);
            issue(C_ACT, 2, 1'b0);
            issue(C_RD, 1, 1'b1);
            issue(C_BST, 0, 1'b0);
            expect_err("R13 stop in burst", 0);
            idle((g > 1) ? g - 2 : 0);
            if (g == 1) begin
                check("R10 gap1 state", st(1), 2);
            end else begin
                issue(C_RD, 2, 1'b0);
                expect_err("R10 other bank", (g <= BL) ? 7 : 0);
            end
            clean();
        end
        issue(C_BST, 1, 1'b0);
        expect_err("R13 stop idle", 0);

        // R3 mask latencies
        begin
            logic [15:0] pat = 16'hB4D2;
            for (int i = 0; i < 16; i++) begin
                dqm = pat[i];
                #1;
                check("R3 write mask", int'(wr_mask_o), int'(pat[i]));
                check("R3 read hiz", int'(rd_hiz_o), (i >= 2) ? int'(pat[i-2]) : 0);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule